// File: doc/BRIEF.md
# 8-bit ALU Result and Status Flag Unit

This block computes the data result and the next condition-code byte for the arithmetic and logic operations of a small 8-bit core. It takes two operands and a 4-bit operation code, and it reads the current status byte. It combinationally produces the result and the status byte that the operation would leave behind. Thirteen operations are defined, so a 3-bit code is not wide enough and a 4-bit code is used.

A thin registered wrapper holds the status byte between operations. The byte is written when an operation is marked valid. The surrounding core can also overwrite the byte directly through a load port, and a load takes priority over a valid operation. The result itself is not registered: writing it back is the job of the register file outside this block.

Carry, half-carry and overflow come from explicit per-bit carry and borrow terms built from the operands and the result. The two chained subtract forms can only keep or clear the zero flag, never set it. This lets a multi-byte compare or subtract finish with a zero flag that covers every byte.

Top module: `alu_status_unit`

## Requirements
- R1: While `rstN` is low, `statusQ` is 0x00. When `loadEn` is high at a rising edge, `statusQ` takes `loadVal` after that edge, whatever `opValid` is.
- R2: The status bits are C=bit 0, Z=bit 1, N=bit 2, V=bit 3, S=bit 4, H=bit 5, T=bit 6 and I=bit 7. No operation changes bits 6 and 7.
- R3: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+C, both modulo 256. With the carry term k=(A&B)|(B&~res)|(~res&A), H=k[3] and C=k[7], and V is bit 7 of (A&B&~res)|(~A&~B&res).
- R4: Code 2 (subtract) gives A-B modulo 256. With the borrow term b=(~A&B)|(B&res)|(res&~A), H=b[3] and C=b[7], and V is bit 7 of (A&~B&~res)|(~A&B&res). Z is set exactly when the result is zero.
- R5: Code 3 (subtract with carry) and code 4 (compare with carry) give A-B-C modulo 256, with C, H and V as in R4. Z becomes 0 when the result is nonzero and otherwise keeps its old value.
- R6: Code 5 (increment) gives A+1 and code 6 (decrement) gives A-1. V is set only for a result of 0x80 (increment) or 0x7F (decrement). C and H are unchanged.
- R7: Code 7 (one's complement) gives 0xFF-A, sets C to 1 and clears V. H is unchanged.
- R8: Codes 8, 9 and 10 give A AND B, A OR B and A XOR B. They clear V and leave C and H unchanged.
- R9: Code 11 (arithmetic shift right) gives A shifted right by one with bit 7 kept. C takes the old A[0], V = N xor C, and H is unchanged.
- R10: Code 12 (nibble swap) gives {A[3:0],A[7:4]} and changes no flag. Codes 13 to 15 are reserved: they pass A to the result and change no flag.
- R11: For codes 0 to 11, N is bit 7 of the result and S = N xor V. Z follows the result (set exactly when it is zero) except where R5 applies.
- R12: At a rising edge with `opValid` high and `loadEn` low, `statusQ` takes `nextStatus`. With both low, `statusQ` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Commits `nextStatus` into the status register |
| opCode | input | 4 | Operation select, codes 0 to 15 |
| opA | input | 8 | First operand (the only operand of single-operand codes) |
| opB | input | 8 | Second operand |
| loadEn | input | 1 | Direct status write, priority over `opValid` |
| loadVal | input | 8 | Value for a direct status write |
| result | output | 8 | Combinational operation result |
| nextStatus | output | 8 | Combinational status after the operation |
| statusQ | output | 8 | Registered status byte |

## Verification
`result` and `nextStatus` are combinational, so they are due in the same cycle as the operands. `statusQ` is due one rising edge after a valid operation or a load. The bench drives inputs on the falling edge. For the sweep it holds `opValid` low and compares the combinational outputs 1 ns later against its model, so the register stays put while every operand pair is tried. In the sequential phase it predicts the register value from its own copy of the status byte and compares `statusQ` on the next falling edge, after the one rising edge that is meant to update it.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int STATUS_W = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CPC  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_COM  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_ASR  = 4'd11,
    OP_SWAP = 4'd12
  } opcode_e;

  typedef enum logic [3:0] {
    SEL_ARITH,
    SEL_INC,
    SEL_DEC,
    SEL_COM,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_ASR,
    SEL_SWAP,
    SEL_PASS
  } resSel_e;

  typedef struct packed {
    resSel_e resSel;
    logic    subtract;
    logic    useCarry;
    logic    stickyZero;
    logic    wrC;
    logic    wrH;
    logic    wrV;
    logic    wrZns;
  } strobe_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic [3:0] opCode,
  output strobe_t    strobes
);

  always_comb begin
    strobes = '0;
    strobes.resSel = SEL_PASS;
    case (opCode)
      OP_ADD, OP_ADC: begin
        strobes.resSel   = SEL_ARITH;
        strobes.useCarry = (opCode == OP_ADC);
        strobes.wrC      = 1'b1;
        strobes.wrH      = 1'b1;
        strobes.wrV      = 1'b1;
        strobes.wrZns    = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CPC: begin
        strobes.resSel     = SEL_ARITH;
        strobes.subtract   = 1'b1;
        strobes.useCarry   = (opCode != OP_SUB);
        strobes.stickyZero = (opCode != OP_SUB);
        strobes.wrC        = 1'b1;
        strobes.wrH        = 1'b1;
        strobes.wrV        = 1'b1;
        strobes.wrZns      = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobes.resSel = (opCode == OP_INC) ? SEL_INC : SEL_DEC;
        strobes.wrV    = 1'b1;
        strobes.wrZns  = 1'b1;
      end
      OP_COM: begin
        strobes.resSel = SEL_COM;
        strobes.wrC    = 1'b1;
        strobes.wrV    = 1'b1;
        strobes.wrZns  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.resSel = (opCode == OP_AND) ? SEL_AND :
                         (opCode == OP_OR)  ? SEL_OR  : SEL_XOR;
        strobes.wrV    = 1'b1;
        strobes.wrZns  = 1'b1;
      end
      OP_ASR: begin
        strobes.resSel = SEL_ASR;
        strobes.wrC    = 1'b1;
        strobes.wrV    = 1'b1;
        strobes.wrZns  = 1'b1;
      end
      OP_SWAP: strobes.resSel = SEL_SWAP;
      default: strobes.resSel = SEL_PASS;
    endcase
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  strobe_t             strobes,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [DATA_W-1:0]   result,
  output logic [STATUS_W-1:0] statusOut
);

  localparam int MSB  = DATA_W - 1;
  localparam int HBIT = DATA_W / 2 - 1;
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic carryBit(input logic a, input logic b, input logic r);
    return (a & b) | (b & ~r) | (~r & a);
  endfunction

  function automatic logic borrowBit(input logic a, input logic b, input logic r);
    return (~a & b) | (b & r) | (r & ~a);
  endfunction

  logic              carryIn;
  logic [DATA_W-1:0] carryWord;
  logic [DATA_W-1:0] addRes;
  logic [DATA_W-1:0] subRes;
  logic [DATA_W-1:0] arithRes;
  logic              cNew;
  logic              hNew;
  logic              vNew;
  logic              zeroRes;

  assign carryIn   = strobes.useCarry & statusIn[FLAG_C];
  assign carryWord = {{(DATA_W-1){1'b0}}, carryIn};
  assign addRes    = opA + opB + carryWord;
  assign subRes    = opA - opB - carryWord;
  assign arithRes  = strobes.subtract ? subRes : addRes;

  always_comb begin
    case (strobes.resSel)
      SEL_ARITH: result = arithRes;
      SEL_INC:   result = opA + ONE;
      SEL_DEC:   result = opA - ONE;
      SEL_COM:   result = ~opA;
      SEL_AND:   result = opA & opB;
      SEL_OR:    result = opA | opB;
      SEL_XOR:   result = opA ^ opB;
      SEL_ASR:   result = {opA[MSB], opA[MSB:1]};
      SEL_SWAP:  result = {opA[HBIT:0], opA[MSB:HBIT+1]};
      default:   result = opA;
    endcase
  end

  assign zeroRes = (result == '0);

  always_comb begin
    cNew = 1'b0;
    hNew = 1'b0;
    vNew = 1'b0;
    case (strobes.resSel)
      SEL_ARITH: begin
        if (strobes.subtract) begin
          cNew = borrowBit(opA[MSB], opB[MSB], arithRes[MSB]);
          hNew = borrowBit(opA[HBIT], opB[HBIT], arithRes[HBIT]);
          vNew = (opA[MSB] & ~opB[MSB] & ~arithRes[MSB]) |
                 (~opA[MSB] & opB[MSB] & arithRes[MSB]);
        end else begin
          cNew = carryBit(opA[MSB], opB[MSB], arithRes[MSB]);
          hNew = carryBit(opA[HBIT], opB[HBIT], arithRes[HBIT]);
          vNew = (opA[MSB] & opB[MSB] & ~arithRes[MSB]) |
                 (~opA[MSB] & ~opB[MSB] & arithRes[MSB]);
        end
      end
      SEL_INC: vNew = (result == MIN_NEG);
      SEL_DEC: vNew = (result == MAX_POS);
      SEL_COM: cNew = 1'b1;
      SEL_ASR: begin
        cNew = opA[0];
        vNew = result[MSB] ^ opA[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    statusOut = statusIn;
    if (strobes.wrC) statusOut[FLAG_C] = cNew;
    if (strobes.wrH) statusOut[FLAG_H] = hNew;
    if (strobes.wrV) statusOut[FLAG_V] = vNew;
    if (strobes.wrZns) begin
      statusOut[FLAG_Z] = strobes.stickyZero ? (statusIn[FLAG_Z] & zeroRes) : zeroRes;
      statusOut[FLAG_N] = result[MSB];
      statusOut[FLAG_S] = result[MSB] ^ statusOut[FLAG_V];
    end
  end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              loadEn,
  input  logic [7:0]        loadVal,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        nextStatus,
  output logic [7:0]        statusQ
);

  strobe_t strobes;

  flag_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .statusIn  (statusQ),
    .result    (result),
    .statusOut (nextStatus)
  );

  always_ff @(posedge clk) begin
    if (!rstN)        statusQ <= '0;
    else if (loadEn)  statusQ <= loadVal;
    else if (opValid) statusQ <= nextStatus;
  end

endmodule

// File: rtl/alu_status_unit_chk.sv
module alu_status_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic              loadEn,
  input logic [7:0]        loadVal,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        nextStatus,
  input logic [7:0]        statusQ
);

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> statusQ == 8'h00);

  a_r1_load: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> statusQ == $past(loadVal));

  a_r2_ti_kept: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !loadEn) |=> statusQ[7:6] == $past(statusQ[7:6]));

  a_r7_com_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_COM) |-> (nextStatus[FLAG_C] && !nextStatus[FLAG_V] && result == ~opA));

  a_r10_no_flag_change: assert property (@(posedge clk) disable iff (!rstN)
    (opCode >= OP_SWAP) |-> nextStatus == statusQ);

  a_r11_sign_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opCode <= OP_ASR) |-> (nextStatus[FLAG_N] == result[DATA_W-1] &&
                            nextStatus[FLAG_S] == (nextStatus[FLAG_N] ^ nextStatus[FLAG_V])));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !loadEn) |=> $stable(statusQ));

  a_r12_commit: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !loadEn) |=> statusQ == $past(nextStatus));

endmodule

bind alu_status_unit alu_status_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opCode     (opCode),
  .opA        (opA),
  .loadEn     (loadEn),
  .loadVal    (loadVal),
  .result     (result),
  .nextStatus (nextStatus),
  .statusQ    (statusQ)
);

// File: tb/alu_status_unit_test.sv
`timescale 1ns/100ps
module alu_status_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic       loadEn = 1'b0;
  logic [7:0] loadVal = 8'd0;
  logic [7:0] result;
  logic [7:0] nextStatus;
  logic [7:0] statusQ;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_status_unit uut (
    .clk (clk), .rstN (rstN), .opValid (opValid), .opCode (opCode),
    .opA (opA), .opB (opB), .loadEn (loadEn), .loadVal (loadVal),
    .result (result), .nextStatus (nextStatus), .statusQ (statusQ)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagFor(input int op);
    case (op)
      0, 1:    return "R3";
      2:       return "R4";
      3, 4:    return "R5";
      5, 6:    return "R6";
      7:       return "R7";
      8, 9, 10: return "R8";
      11:      return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model: returns {result, status}
  function automatic logic [15:0] refModel(input int op, input int a, input int b, input logic [7:0] st);
    int res, full, ce, sa, sb, sv;
    bit upd, sticky;
    logic [7:0] ns;
    ns = st;
    upd = 1'b1;
    sticky = 1'b0;
    res = a;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        ce = (op == 1) ? int'(st[0]) : 0;
        full = a + b + ce;
        res = full % 256;
        ns[0] = (full > 255);
        ns[5] = (((a % 16) + (b % 16) + ce) > 15);
        sv = sa + sb + ce;
        ns[3] = (sv > 127) || (sv < -128);
      end
      2, 3, 4: begin
        ce = (op == 2) ? 0 : int'(st[0]);
        full = a - b - ce;
        res = (full + 512) % 256;
        ns[0] = (full < 0);
        ns[5] = (((a % 16) - (b % 16) - ce) < 0);
        sv = sa - sb - ce;
        ns[3] = (sv > 127) || (sv < -128);
        sticky = (op != 2);
      end
      5: begin res = (a + 1) % 256; ns[3] = (res == 128); end
      6: begin res = (a + 255) % 256; ns[3] = (res == 127); end
      7: begin res = 255 - a; ns[0] = 1'b1; ns[3] = 1'b0; end
      8: begin res = a & b; ns[3] = 1'b0; end
      9: begin res = a | b; ns[3] = 1'b0; end
      10: begin res = a ^ b; ns[3] = 1'b0; end
      11: begin
        res = (a / 2) + (a >= 128 ? 128 : 0);
        ns[0] = (a % 2 == 1);
        ns[3] = (res >= 128) != (a % 2 == 1);
      end
      12: begin res = (a % 16) * 16 + a / 16; upd = 1'b0; end
      default: begin res = a; upd = 1'b0; end
    endcase
    if (upd) begin
      ns[2] = (res >= 128);
      ns[1] = sticky ? (st[1] && res == 0) : (res == 0);
      ns[4] = ns[2] ^ ns[3];
    end
    return {res[7:0], ns};
  endfunction

  task automatic loadStatus(input logic [7:0] v);
    @(negedge clk);
    loadEn = 1'b1;
    loadVal = v;
    opValid = 1'b1;  // load has priority
    @(negedge clk);
    loadEn = 1'b0;
    opValid = 1'b0;
    check("R1", "load", int'(statusQ), int'(v));
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] modelSt;
    logic [15:0] exp;
    logic [7:0] bList [16];
    bList = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h3F, 8'h7F, 8'h80,
              8'h81, 8'hAA, 8'h55, 8'hF0, 8'hFE, 8'hFF, 8'h7E, 8'h00};

    // Reset, with an operation pending: R1
    opValid = 1'b1;
    opCode = 4'd7;
    repeat (3) @(negedge clk);
    check("R1", "reset status", int'(statusQ), 0);
    rstN = 1'b1;
    opValid = 1'b0;
    @(negedge clk);
    check("R12", "idle hold after reset", int'(statusQ), 0);

    // Sweep: combinational outputs against the model, register held
    for (int op = 0; op < 16; op++) begin
      for (int cs = 0; cs < 2; cs++) begin
        // cs=1: C, Z, H, T, I set; cs=0: only T set
        modelSt = (cs == 1) ? 8'hE3 : 8'h40;
        loadStatus(modelSt);
        opCode = 4'(op);
        for (int a = 0; a < 256; a++) begin
          for (int bi = 0; bi < 16; bi++) begin
            @(negedge clk);
            opA = 8'(a);
            opB = (bi == 15) ? 8'(a) : bList[bi];
            #1;
            exp = refModel(op, a, int'(opB), modelSt);
            check(tagFor(op), "result", int'(result), int'(exp[15:8]));
            check(tagFor(op), "status R2 R11", int'(nextStatus), int'(exp[7:0]));
          end
        end
        check("R12", "held during sweep", int'(statusQ), int'(modelSt));
      end
    end

    // Sequential phase: register follows the model edge by edge
    modelSt = 8'h80;
    loadStatus(modelSt);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k > 0) check("R12", "registered status", int'(statusQ), int'(modelSt));
      opCode = 4'($urandom_range(0, 15));
      opA = 8'($urandom);
      opB = 8'($urandom);
      opValid = ($urandom_range(0, 3) != 0);
      loadEn = ($urandom_range(0, 31) == 0);
      loadVal = 8'($urandom);
      if (loadEn) modelSt = loadVal;
      else if (opValid) begin
        exp = refModel(int'(opCode), int'(opA), int'(opB), modelSt);
        modelSt = exp[7:0];
      end
    end
    @(negedge clk);
    check("R12", "registered status final", int'(statusQ), int'(modelSt));
    opValid = 1'b0;
    loadEn = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule